// File: doc/BRIEF.md
# Retry-on-Error Instruction Sequencer

This block steps a small processor through its fetch, execute and writeback states and keeps the program counter. The ALU next to it checks its own results and raises a one-cycle error pulse when a result does not match its check symbol. The sequencer stores that pulse in a sticky flag. At the next fetch it reads the flag and decides what to do. With no error, the program counter moves on. With an error, the counter is held and the same instruction and operands are issued again, flagged as a re-execution.

A data upset from a transient goes away on re-execution. A fault in the configuration cells does not, so it shows up again. When the error comes back on the last allowed retry, the sequencer stops issuing and raises a reconfigure request. It keeps the request high until the scrubbing logic acknowledges it. It then re-issues the held instruction once more with a fresh retry budget. In error-free running, no cycle is lost: each instruction takes exactly three cycles.

Top module: `reexec_ctrl`

## Requirements
- R1: A synchronous reset gives pc = 0 with issue, reexec and reconf_req all low. The first issue of pc 0 appears one clock edge after reset is released.
- R2: With no errors, issue is high for one cycle in every three. Each issue carries pc one greater than the previous one, modulo 2^PC_W.
- R3: An alu_err pulse in the issue cycle or in the cycle after it is latched. The next issue then carries the same pc, with reexec high, three cycles after the previous issue.
- R4: When a re-execution completes without error, the next issue carries pc + 1 with reexec low.
- R5: An error on the MAX_RETRY-th re-execution of an instruction raises reconf_req three cycles after that issue. No issue occurs while reconf_req is high.
- R6: reconf_req stays high until reconf_done is sampled high. In the next cycle reconf_req is low and the held pc is issued with reexec high.
- R7: After a reconfiguration the retry budget starts from zero. A single error on the re-issue after reconfiguration leads to a plain re-execution, not a new request.
- R8: An alu_err pulse in the fetch cycle and a reconf_done pulse while no request is pending have no effect on the pc sequence or on issue timing.
- R9: Reset takes effect from any state, including while a reconfigure request is pending, and drops reconf_req.
- R10: reexec is never high without issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_err | input | 1 | Mismatch pulse from the self-checking ALU |
| reconf_done | input | 1 | Acknowledge that the configuration scrub has finished |
| pc | output | PC_W | Address of the instruction being issued |
| issue | output | 1 | One-cycle strobe: the instruction at pc goes to the ALU |
| reexec | output | 1 | High with issue when the issue repeats a failed instruction |
| reconf_req | output | 1 | Request to scrub the configuration; held until acknowledged |

## Verification
The bench builds the sequencer with PC_W = 4 and MAX_RETRY = 1. A narrow counter makes the wrap from 15 to 0 reachable within a few dozen instructions. A single retry means two consecutive error pulses are enough to push it into the reconfigure wait. With these values, both the transient and the persistent error patterns can be driven against several program-counter values. The bench also covers errors in both the issue and writeback cycles, and an acknowledge arriving after many cycles of waiting.

// File: rtl/reexec_pkg.sv
package reexec_pkg;
  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_EXEC   = 2'd1,
    ST_WB     = 2'd2,
    ST_RECONF = 2'd3
  } seq_state_e;
endpackage

// File: rtl/reexec_err_latch.sv
// Sticky error flag: set by a checker pulse, cleared when the fetch consumes it.
module reexec_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/reexec_tally.sv
// Counts re-executions of the current instruction; reports when the budget is used up.
module reexec_tally #(
  parameter int MAX_RETRY = 1,
  parameter int CNT_W     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             spent_o
);
  assign spent_o = (cnt_o >= CNT_W'(MAX_RETRY));

  always_ff @(posedge clk) begin
    if (rst || clr_i)             cnt_o <= '0;
    else if (inc_i && !spent_o)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/reexec_pc.sv
// Program counter with a single advance input; wraps naturally.
module reexec_pc #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk) begin
    if (rst)        pc_o <= '0;
    else if (adv_i) pc_o <= pc_o + 1'b1;
  end
endmodule

// File: rtl/reexec_ctrl.sv
module reexec_ctrl
  import reexec_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int MAX_RETRY = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alu_err,
  input  logic            reconf_done,
  output logic [PC_W-1:0] pc,
  output logic            issue,
  output logic            reexec,
  output logic            reconf_req
);
  localparam int CNT_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  seq_state_e       state_q, state_d;
  logic             ran_q, ran_d;       // an instruction has been issued since reset
  logic             again_q, again_d;   // the pending issue repeats a failed one
  logic             err_flag, err_set, err_clr;
  logic             pc_adv;
  logic             tally_inc, tally_clr, tally_spent;
  logic [CNT_W-1:0] tally_cnt;

  // The ALU only produces checked results in the execute and writeback cycles.
  assign err_set = alu_err && (state_q == ST_EXEC || state_q == ST_WB);

  reexec_err_latch u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (err_set),
    .clr_i  (err_clr),
    .flag_o (err_flag)
  );

  reexec_tally #(
    .MAX_RETRY (MAX_RETRY),
    .CNT_W     (CNT_W)
  ) u_tally (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (tally_clr),
    .inc_i   (tally_inc),
    .cnt_o   (tally_cnt),
    .spent_o (tally_spent)
  );

  reexec_pc #(
    .PC_W (PC_W)
  ) u_pc (
    .clk   (clk),
    .rst   (rst),
    .adv_i (pc_adv),
    .pc_o  (pc)
  );

  always_comb begin
    state_d   = state_q;
    ran_d     = ran_q;
    again_d   = again_q;
    err_clr   = 1'b0;
    pc_adv    = 1'b0;
    tally_inc = 1'b0;
    tally_clr = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        err_clr = 1'b1;
        ran_d   = 1'b1;
        if (err_flag) begin
          again_d = 1'b1;
          if (tally_spent) begin
            state_d = ST_RECONF;
          end else begin
            tally_inc = 1'b1;
            state_d   = ST_EXEC;
          end
        end else begin
          again_d   = 1'b0;
          pc_adv    = ran_q;
          tally_clr = 1'b1;
          state_d   = ST_EXEC;
        end
      end
      ST_EXEC: state_d = ST_WB;
      ST_WB:   state_d = ST_FETCH;
      ST_RECONF: begin
        if (reconf_done) begin
          tally_clr = 1'b1;
          again_d   = 1'b1;
          state_d   = ST_EXEC;
        end
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      ran_q   <= 1'b0;
      again_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ran_q   <= ran_d;
      again_q <= again_d;
    end
  end

  assign issue      = (state_q == ST_EXEC);
  assign reexec     = issue && again_q;
  assign reconf_req = (state_q == ST_RECONF);

  logic unused_cnt;
  assign unused_cnt = ^tally_cnt;
endmodule

// File: rtl/reexec_ctrl_chk.sv
module reexec_ctrl_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            reconf_done,
  input logic [PC_W-1:0] pc,
  input logic            issue,
  input logic            reexec,
  input logic            reconf_req
);
  logic [PC_W-1:0] last_pc;
  logic            seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      last_pc <= '0;
    end else if (issue) begin
      seen    <= 1'b1;
      last_pc <= pc;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && !issue && !reconf_req));

  p_issue_gap_r2: assert property (@(posedge clk) disable iff (rst)
    issue |=> !issue);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (issue && !reexec && seen) |-> (pc == last_pc + 1'b1));

  p_same_pc_r3: assert property (@(posedge clk) disable iff (rst)
    (issue && reexec && seen) |-> (pc == last_pc));

  p_req_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    reconf_req |-> !issue);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (reconf_req && !reconf_done) |=> reconf_req);

  p_req_release_r6: assert property (@(posedge clk) disable iff (rst)
    (reconf_req && reconf_done) |=> (!reconf_req && issue && reexec && pc == $past(pc)));

  p_reexec_issue_r10: assert property (@(posedge clk) disable iff (rst)
    reexec |-> issue);
endmodule

bind reexec_ctrl reexec_ctrl_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reconf_done (reconf_done),
  .pc          (pc),
  .issue       (issue),
  .reexec      (reexec),
  .reconf_req  (reconf_req)
);

// File: tb/reexec_ctrl_bench.sv
module reexec_ctrl_bench;
  localparam int BW = 4;
  localparam int MR = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alu_err = 1'b0;
  logic          reconf_done = 1'b0;
  logic [BW-1:0] pc;
  logic          issue, reexec, reconf_req;

  int n_chk = 0;
  int n_bad = 0;
  int stray = 0;
  int exp_pc = 0;

  always #4 clk = ~clk;

  reexec_ctrl #(.PC_W(BW), .MAX_RETRY(MR)) u_reexec_ctrl (
    .clk (clk), .rst (rst), .alu_err (alu_err), .reconf_done (reconf_done),
    .pc (pc), .issue (issue), .reexec (reexec), .reconf_req (reconf_req)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_issue(output int gap, output int p, output bit rx, output bit req_seen);
    gap = 0; req_seen = 1'b0;
    do begin
      @(negedge clk);
      gap++;
      if (reconf_req) req_seen = 1'b1;
      if (reexec && !issue) stray++;
    end while (!issue && gap < 200);
    p  = int'(pc);
    rx = reexec;
  endtask

  task automatic pulse_err();  // call at a negedge; ends one negedge later
    alu_err = 1'b1;
    @(negedge clk);
    alu_err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(pc == 0, "R1", "pc in reset", int'(pc), 0);
    check(!issue && !reexec && !reconf_req, "R1", "outputs in reset",
          int'({issue, reexec, reconf_req}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(issue && pc == 0, "R1", "first issue pc", int'(pc), 0);
    check(!reexec, "R1", "first issue reexec", int'(reexec), 0);
    exp_pc = 0;
  endtask

  task automatic t_normal(input int n);
    int g, p; bit rx, rq;
    for (int i = 0; i < n; i++) begin
      wait_issue(g, p, rx, rq);
      exp_pc = (exp_pc + 1) % (1 << BW);
      check(g == 3, "R2", "issue spacing", g, 3);
      check(p == exp_pc, "R2", "pc step", p, exp_pc);
      check(!rx, "R2", "no reexec", int'(rx), 0);
    end
  endtask

  task automatic t_single_err(input bit in_wb);
    int g, p; bit rx, rq;
    wait_issue(g, p, rx, rq);
    exp_pc = (exp_pc + 1) % (1 << BW);
    if (in_wb) @(negedge clk);
    pulse_err();
    wait_issue(g, p, rx, rq);
    check(p == exp_pc, "R3", "retry holds pc", p, exp_pc);
    check(rx, "R3", "retry flagged", int'(rx), 1);
    check(g == (in_wb ? 1 : 2), "R3", "retry spacing", g, in_wb ? 1 : 2);
    wait_issue(g, p, rx, rq);
    exp_pc = (exp_pc + 1) % (1 << BW);
    check(p == exp_pc && !rx, "R4", "advance after good retry", p, exp_pc);
  endtask

  task automatic t_ignore();
    int g, p; bit rx, rq;
    wait_issue(g, p, rx, rq);
    exp_pc = (exp_pc + 1) % (1 << BW);
    @(negedge clk);
    @(negedge clk);           // fetch cycle
    alu_err = 1'b1; reconf_done = 1'b1;
    @(negedge clk);
    alu_err = 1'b0; reconf_done = 1'b0;
    exp_pc = (exp_pc + 1) % (1 << BW);
    check(issue && int'(pc) == exp_pc && !reexec, "R8", "pulses in fetch ignored",
          int'(pc), exp_pc);
    wait_issue(g, p, rx, rq);
    exp_pc = (exp_pc + 1) % (1 << BW);
    check(p == exp_pc && !rx && g == 3, "R8", "no late retry", p, exp_pc);
    check(!rq, "R8", "no request", int'(rq), 0);
  endtask

  task automatic reach_reconf();
    int g, p; bit rx, rq;
    wait_issue(g, p, rx, rq);
    exp_pc = (exp_pc + 1) % (1 << BW);
    pulse_err();
    wait_issue(g, p, rx, rq);
    check(p == exp_pc && rx, "R3", "first retry", p, exp_pc);
    pulse_err();               // now in writeback
    @(negedge clk);            // fetch
    check(!reconf_req, "R5", "request not early", int'(reconf_req), 0);
    @(negedge clk);
    check(reconf_req, "R5", "request raised", int'(reconf_req), 1);
    check(!issue, "R5", "no issue with request", int'(issue), 0);
  endtask

  task automatic t_persist();
    int g, p; bit rx, rq;
    reach_reconf();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(reconf_req && !issue, "R6", "request held", int'(reconf_req), 1);
    end
    reconf_done = 1'b1;
    @(negedge clk);
    reconf_done = 1'b0;
    check(!reconf_req, "R6", "request dropped", int'(reconf_req), 0);
    check(issue && reexec && int'(pc) == exp_pc, "R6", "reissue after scrub",
          int'(pc), exp_pc);
    wait_issue(g, p, rx, rq);
    exp_pc = (exp_pc + 1) % (1 << BW);
    check(p == exp_pc && !rx, "R4", "advance after scrub", p, exp_pc);
  endtask

  task automatic t_post_reconf();
    int g, p; bit rx, rq;
    reach_reconf();
    @(negedge clk);
    reconf_done = 1'b1;
    @(negedge clk);
    reconf_done = 1'b0;
    check(issue && reexec, "R6", "reissue", int'(issue), 1);
    pulse_err();
    wait_issue(g, p, rx, rq);
    check(!rq, "R7", "no new request", int'(rq), 0);
    check(p == exp_pc && rx, "R7", "plain retry after scrub", p, exp_pc);
    wait_issue(g, p, rx, rq);
    exp_pc = (exp_pc + 1) % (1 << BW);
    check(p == exp_pc && !rx, "R7", "advance", p, exp_pc);
  endtask

  task automatic t_reset_in_reconf();
    int g, p; bit rx, rq;
    reach_reconf();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!reconf_req, "R9", "reset drops request", int'(reconf_req), 0);
    check(pc == 0 && !issue, "R9", "reset pc", int'(pc), 0);
    rst = 1'b0;
    wait_issue(g, p, rx, rq);
    check(p == 0 && !rx && !rq, "R9", "restart at zero", p, 0);
    exp_pc = 0;
  endtask

  initial begin
    do_reset();
    t_normal(20);              // passes the wrap 15 -> 0
    t_single_err(1'b0);
    t_single_err(1'b1);
    t_ignore();
    t_persist();
    t_post_reconf();
    t_reset_in_reconf();
    t_normal(3);
    check(stray == 0, "R10", "reexec without issue", stray, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 5000, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule